// File: doc/BRIEF.md
# Framed Command Block CRC Checker

This block sits behind a byte-wide receive path and checks one framed block at a time. A block opens with a length byte that gives the total size of the block: the length byte itself, the packet bytes and the two check bytes. The packet bytes (command, parameters and data, or a response) come next, and a 16-bit CRC trailer closes the block. The checker passes packet bytes straight through on a valid/ready output and computes the CRC as the bytes go by. When the final byte arrives it reports a one-cycle completion strobe with a pass/fail flag.

A length byte outside the legal range is rejected with an error code, and no frame is opened. A CRC mismatch raises the completion strobe and an error code together. A synchronous abort input, driven for example by a protocol timeout, drops any partial frame and returns the checker to waiting for a length byte.

Top module: `cmdblk_crc_check`

## Requirements
- R1: After reset, done_o, crc_ok_o, err_o and pl_valid_o are low, err_code_o is 0, in_ready_o is high, and the next accepted byte is taken as a length byte.
- R2: A length byte below 4 or above 39 makes err_o high with err_code_o = 1 (length error) in the cycle after it is accepted, with done_o low. No byte is forwarded, and the next accepted byte is again a length byte.
- R3: For a legal length N, exactly the N-3 bytes after the length byte appear on pl_data_o with pl_valid_o high, in arrival order. The length byte and the two trailer bytes are never forwarded.
- R4: While a packet byte is presented and pl_ready_i is low, in_ready_o is low and the byte is not consumed. For length and trailer bytes, and while idle, in_ready_o is high.
- R5: The CRC uses polynomial 0x8005 and starts from 0. Each byte is fed least significant bit first, and register bit 15 XOR the input bit is the feedback. There is no final inversion or reflection. The CRC covers the length byte and the packet bytes only.
- R6: The first trailer byte is the CRC low byte and the last is the high byte. done_o pulses for one cycle, in the cycle after the last byte is accepted, with crc_ok_o high exactly when the trailer matches. crc_ok_o is never high without done_o.
- R7: On a mismatch, done_o, err_o and err_code_o = 2 (CRC error) all appear in the same cycle, with crc_ok_o low. err_code_o is 0 whenever err_o is low.
- R8: A new length byte may be accepted in the cycle right after the last byte of a frame, so frames can run back to back with no gap.
- R9: abort_i high at a clock edge drops any byte offered in that cycle and any partial frame. In the following cycle done_o and err_o are low, and the next accepted byte is taken as a length byte. pl_valid_o is low while abort_i is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| abort_i | input | 1 | Synchronous discard of any partial frame |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_ready_o | output | 1 | Input byte accepted when high together with in_valid_i |
| pl_valid_o | output | 1 | Packet byte valid |
| pl_data_o | output | 8 | Packet byte |
| pl_ready_i | input | 1 | Downstream accepts the packet byte |
| done_o | output | 1 | One-cycle strobe at the end of a frame |
| crc_ok_o | output | 1 | Trailer matched; valid with done_o |
| err_o | output | 1 | One-cycle error strobe |
| err_code_o | output | 2 | 0 none, 1 length error, 2 CRC error |

## Verification
The checker properties assume the upstream source keeps in_data_i unchanged while in_valid_i is high and in_ready_o is low, so a stalled packet byte is the same byte when it is finally taken. The stimulus keeps to this: it changes the byte only after the reference model has seen it accepted. Random stalls on pl_ready_i exercise the hold path, and the abort and length-error properties rely only on the registered result stage being cleared by a cycle with no accepted byte, which the stimulus produces through mid-frame and mid-trailer aborts.

// File: rtl/cmdblk_pkg.sv
package cmdblk_pkg;

    localparam int BYTE_W = 8;
    localparam int CRC_W  = 16;
    localparam logic [CRC_W-1:0] CRC_POLY_DEF = 16'h8005;
    localparam logic [CRC_W-1:0] CRC_SEED_DEF = 16'h0000;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_LEN  = 2'd1,
        ERR_CRC  = 2'd2
    } blk_err_e;

    typedef enum logic [1:0] {
        ROLE_COUNT   = 2'd0,
        ROLE_PAYLOAD = 2'd1,
        ROLE_TRL_LO  = 2'd2,
        ROLE_TRL_HI  = 2'd3
    } blk_role_e;

    typedef struct packed {
        logic     done;
        logic     ok;
        logic     err;
        blk_err_e code;
    } blk_result_t;

    localparam blk_result_t RESULT_IDLE = '{done: 1'b0, ok: 1'b0, err: 1'b0, code: ERR_NONE};

    // One byte through the shift register, low bit first.
    function automatic logic [CRC_W-1:0] crc_step_byte(
        input logic [CRC_W-1:0]  crc_in,
        input logic [BYTE_W-1:0] din,
        input logic [CRC_W-1:0]  poly
    );
        logic [CRC_W-1:0] c;
        logic             fb;
        c = crc_in;
        for (int i = 0; i < BYTE_W; i++) begin
            fb = c[CRC_W-1] ^ din[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ poly;
        end
        return c;
    endfunction

endpackage

// File: rtl/cmdblk_crc_acc.sv
module cmdblk_crc_acc
    import cmdblk_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = CRC_POLY_DEF,
    parameter logic [CRC_W-1:0] SEED = CRC_SEED_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              upd_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [CRC_W-1:0]  crc_o
);
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] base;

    assign base = start_i ? SEED : crc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= SEED;
        end else if (start_i || upd_i) begin
            crc_q <= crc_step_byte(base, byte_i, POLY);
        end
    end

    assign crc_o = crc_q;
endmodule

// File: rtl/cmdblk_len_track.sv
module cmdblk_len_track
    import cmdblk_pkg::*;
#(
    parameter int MIN_LEN = 4,
    parameter int MAX_LEN = 39
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              abort_i,
    input  logic              take_i,
    input  logic [BYTE_W-1:0] byte_i,
    output blk_role_e         role_o,
    output logic              len_ok_o
);
    localparam int CNT_W = $clog2(MAX_LEN + 1);
    localparam logic [CNT_W-1:0] REM_LO = CNT_W'(2);
    localparam logic [CNT_W-1:0] REM_HI = CNT_W'(1);

    logic             busy_q;
    logic [CNT_W-1:0] rem_q;

    assign len_ok_o = (byte_i >= BYTE_W'(MIN_LEN)) && (byte_i <= BYTE_W'(MAX_LEN));

    always_comb begin
        if (!busy_q)              role_o = ROLE_COUNT;
        else if (rem_q > REM_LO)  role_o = ROLE_PAYLOAD;
        else if (rem_q == REM_LO) role_o = ROLE_TRL_LO;
        else                      role_o = ROLE_TRL_HI;
    end

    always_ff @(posedge clk) begin
        if (rst || abort_i) begin
            busy_q <= 1'b0;
            rem_q  <= '0;
        end else if (take_i) begin
            if (!busy_q) begin
                busy_q <= len_ok_o;
                rem_q  <= CNT_W'(byte_i - BYTE_W'(1));
            end else begin
                rem_q <= rem_q - CNT_W'(1);
                if (rem_q == REM_HI) busy_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cmdblk_trailer_cmp.sv
module cmdblk_trailer_cmp
    import cmdblk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_lo_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [CRC_W-1:0]  crc_i,
    output logic              match_o
);
    logic [BYTE_W-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst)           lo_q <= '0;
        else if (cap_lo_i) lo_q <= byte_i;
    end

    // The current byte is the high half of the received check value.
    assign match_o = ({byte_i, lo_q} == crc_i);
endmodule

// File: rtl/cmdblk_crc_check.sv
module cmdblk_crc_check
    import cmdblk_pkg::*;
#(
    parameter int                MIN_LEN = 4,
    parameter int                MAX_LEN = 39,
    parameter logic [CRC_W-1:0]  POLY    = CRC_POLY_DEF,
    parameter logic [CRC_W-1:0]  SEED    = CRC_SEED_DEF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        abort_i,
    input  logic        in_valid_i,
    input  logic [7:0]  in_data_i,
    output logic        in_ready_o,
    output logic        pl_valid_o,
    output logic [7:0]  pl_data_o,
    input  logic        pl_ready_i,
    output logic        done_o,
    output logic        crc_ok_o,
    output logic        err_o,
    output logic [1:0]  err_code_o
);
    blk_role_e        role;
    logic             len_ok;
    logic             take;
    logic             match;
    logic [CRC_W-1:0] crc_now;
    blk_result_t      res_d, res_q;

    cmdblk_len_track #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_len (
        .clk      (clk),
        .rst      (rst),
        .abort_i  (abort_i),
        .take_i   (take),
        .byte_i   (in_data_i),
        .role_o   (role),
        .len_ok_o (len_ok)
    );

    assign in_ready_o = (role != ROLE_PAYLOAD) || pl_ready_i;
    assign take       = in_valid_i && in_ready_o && !abort_i;
    assign pl_valid_o = in_valid_i && (role == ROLE_PAYLOAD) && !abort_i;
    assign pl_data_o  = in_data_i;

    cmdblk_crc_acc #(.POLY(POLY), .SEED(SEED)) u_crc (
        .clk     (clk),
        .rst     (rst),
        .start_i (take && (role == ROLE_COUNT) && len_ok),
        .upd_i   (take && (role == ROLE_PAYLOAD)),
        .byte_i  (in_data_i),
        .crc_o   (crc_now)
    );

    cmdblk_trailer_cmp u_cmp (
        .clk      (clk),
        .rst      (rst),
        .cap_lo_i (take && (role == ROLE_TRL_LO)),
        .byte_i   (in_data_i),
        .crc_i    (crc_now),
        .match_o  (match)
    );

    always_comb begin
        res_d = RESULT_IDLE;
        if (take && (role == ROLE_COUNT) && !len_ok) begin
            res_d.err  = 1'b1;
            res_d.code = ERR_LEN;
        end else if (take && (role == ROLE_TRL_HI)) begin
            res_d.done = 1'b1;
            res_d.ok   = match;
            res_d.err  = !match;
            res_d.code = match ? ERR_NONE : ERR_CRC;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= RESULT_IDLE;
        else     res_q <= res_d;
    end

    assign done_o     = res_q.done;
    assign crc_ok_o   = res_q.ok;
    assign err_o      = res_q.err;
    assign err_code_o = res_q.code;
endmodule

// File: rtl/cmdblk_crc_check_chk.sv
module cmdblk_crc_check_chk (
    input logic       clk,
    input logic       rst,
    input logic       abort_i,
    input logic       in_valid_i,
    input logic       in_ready_o,
    input logic       pl_valid_o,
    input logic       pl_ready_i,
    input logic       done_o,
    input logic       crc_ok_o,
    input logic       err_o,
    input logic [1:0] err_code_o
);
    assert_len_err_no_done_R2: assert property (@(posedge clk) disable iff (rst)
        (err_o && err_code_o == 2'd1) |-> !done_o);

    assert_fwd_needs_input_R3: assert property (@(posedge clk) disable iff (rst)
        pl_valid_o |-> in_valid_i);

    assert_stall_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (pl_valid_o && !pl_ready_i) |-> !in_ready_o);

    assert_ok_only_with_done_R6: assert property (@(posedge clk) disable iff (rst)
        crc_ok_o |-> done_o);

    assert_mismatch_code_R7: assert property (@(posedge clk) disable iff (rst)
        (done_o && !crc_ok_o) |-> (err_o && err_code_o == 2'd2));

    assert_code_needs_err_R7: assert property (@(posedge clk) disable iff (rst)
        (err_code_o != 2'd0) |-> err_o);

    assert_abort_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        abort_i |=> (!done_o && !err_o));

    assert_abort_no_fwd_R9: assert property (@(posedge clk) disable iff (rst)
        abort_i |-> !pl_valid_o);
endmodule

bind cmdblk_crc_check cmdblk_crc_check_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .abort_i    (abort_i),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .pl_valid_o (pl_valid_o),
    .pl_ready_i (pl_ready_i),
    .done_o     (done_o),
    .crc_ok_o   (crc_ok_o),
    .err_o      (err_o),
    .err_code_o (err_code_o)
);

// File: tb/cmdblk_crc_check_tb_top.sv
module cmdblk_crc_check_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       abort_i = 1'b0;
    logic       in_valid_i = 1'b0;
    logic [7:0] in_data_i = 8'h00;
    logic       in_ready_o;
    logic       pl_valid_o;
    logic [7:0] pl_data_o;
    logic       pl_ready_i = 1'b1;
    logic       done_o, crc_ok_o, err_o;
    logic [1:0] err_code_o;

    always #5 clk = ~clk;

    cmdblk_crc_check dut_i (
        .clk(clk), .rst(rst), .abort_i(abort_i),
        .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_ready_o(in_ready_o),
        .pl_valid_o(pl_valid_o), .pl_data_o(pl_data_o), .pl_ready_i(pl_ready_i),
        .done_o(done_o), .crc_ok_o(crc_ok_o), .err_o(err_o), .err_code_o(err_code_o)
    );

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req  = "R1";
    bit    stall_mode = 0;
    int    fwd_seen = 0;

    // reference model state
    bit m_busy = 0;
    int m_rem = 0;
    int m_crc = 0;
    int m_lo = 0;
    bit m_acc = 0;
    bit e_done = 0, e_ok = 0, e_err = 0;
    int e_code = 0;

    function automatic int ref_crc(input int c, input int b);
        int r = c;
        for (int k = 0; k < 8; k++) begin
            int top = (r >> 15) & 1;
            int bit_in = (b >> k) & 1;
            r = (r << 1) & 16'hFFFF;
            if ((top ^ bit_in) != 0) r = r ^ 16'h8005;
        end
        return r;
    endfunction

    task automatic chk(input bit good, input string what, input int act, input int exp);
        n_checks++;
        if (!good) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    function automatic bit m_ready();
        return !(m_busy && m_rem > 2) || pl_ready_i;
    endfunction

    task automatic model_step();
        bit rdy = m_ready();
        e_done = 0; e_ok = 0; e_err = 0; e_code = 0; m_acc = 0;
        if (rst || abort_i) begin
            m_busy = 0;
        end else if (in_valid_i && rdy) begin
            m_acc = 1;
            if (!m_busy) begin
                if (in_data_i < 4 || in_data_i > 39) begin
                    e_err = 1; e_code = 1;
                end else begin
                    m_busy = 1;
                    m_rem = int'(in_data_i) - 1;
                    m_crc = ref_crc(0, in_data_i);
                end
            end else if (m_rem > 2) begin
                m_crc = ref_crc(m_crc, in_data_i);
                m_rem--;
            end else if (m_rem == 2) begin
                m_lo = in_data_i;
                m_rem = 1;
            end else begin
                e_done = 1;
                e_ok = ((int'(in_data_i) << 8) | m_lo) == m_crc;
                e_err = !e_ok;
                e_code = e_ok ? 0 : 2;
                m_busy = 0;
            end
        end
    endtask

    task automatic check_regs();
        chk(done_o === e_done, "done_o", done_o, e_done);
        chk(crc_ok_o === e_ok, "crc_ok_o", crc_ok_o, e_ok);
        chk(err_o === e_err, "err_o", err_o, e_err);
        chk(int'(err_code_o) == e_code, "err_code_o", err_code_o, e_code);
    endtask

    task automatic check_comb();
        bit ev = in_valid_i && m_busy && m_rem > 2 && !abort_i;
        chk(in_ready_o === m_ready(), "in_ready_o", in_ready_o, m_ready());
        chk(pl_valid_o === ev, "pl_valid_o", pl_valid_o, ev);
        if (ev) chk(pl_data_o === in_data_i, "pl_data_o", pl_data_o, in_data_i);
    endtask

    task automatic cycle();
        pl_ready_i = stall_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
        #1;
        check_comb();
        if (pl_valid_o && pl_ready_i) fwd_seen++;
        @(posedge clk);
        #2;
        model_step();
        check_regs();
    endtask

    task automatic send_byte(input logic [7:0] b);
        in_valid_i = 1'b1;
        in_data_i  = b;
        do cycle(); while (!m_acc);
    endtask

    task automatic idle(input int n);
        in_valid_i = 1'b0;
        for (int k = 0; k < n; k++) cycle();
    endtask

    // corrupt: 0 good, 1 flip low trailer bit, 2 flip high trailer bit, 3 swap trailer halves
    task automatic send_frame(input int plen, input int seed, input int corrupt, input bit gaps);
        logic [7:0] q[$];
        int c;
        q.push_back(8'(plen + 3));
        for (int k = 0; k < plen; k++) q.push_back(8'(seed * 37 + k * 11 + (k >> 1)));
        c = 0;
        foreach (q[k]) c = ref_crc(c, q[k]);
        case (corrupt)
            1: c = c ^ 16'h0001;
            2: c = c ^ 16'h8000;
            3: c = ((c & 8'hFF) << 8) | (c >> 8);
            default: ;
        endcase
        q.push_back(8'(c & 8'hFF));
        q.push_back(8'(c >> 8));
        fwd_seen = 0;
        foreach (q[k]) begin
            send_byte(q[k]);
            if (gaps && (k % 3 == 1)) idle(1);
        end
        chk(fwd_seen == plen, "R3 forwarded count", fwd_seen, plen);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        cur_req = "R1";
        rst = 1'b1;
        for (int k = 0; k < 3; k++) cycle();
        rst = 1'b0;
        idle(3);

        cur_req = "R5";
        send_frame(1, 1, 0, 0);
        send_frame(5, 2, 0, 1);
        send_frame(36, 3, 0, 0);

        cur_req = "R3";
        for (int k = 0; k < 4; k++) send_frame(3 + k * 7, 10 + k, 0, k[0]);
        idle(2);

        cur_req = "R4";
        stall_mode = 1;
        for (int k = 0; k < 6; k++) send_frame(2 + k * 5, 20 + k, 0, 0);
        stall_mode = 0;
        idle(2);

        cur_req = "R2";
        send_byte(8'd3);
        send_byte(8'd0);
        send_byte(8'd40);
        send_byte(8'd255);
        send_byte(8'd2);
        idle(1);
        send_frame(2, 30, 0, 0);
        idle(1);

        cur_req = "R7";
        send_frame(4, 40, 1, 0);
        send_frame(4, 41, 2, 1);
        idle(1);

        cur_req = "R6";
        send_frame(6, 50, 3, 0);
        send_frame(6, 50, 0, 0);
        idle(1);

        cur_req = "R8";
        for (int k = 0; k < 5; k++) send_frame(1 + k, 60 + k, (k == 2) ? 1 : 0, 0);
        send_byte(8'd1);
        send_frame(3, 66, 0, 0);
        idle(2);

        cur_req = "R9";
        send_byte(8'd10);
        send_byte(8'h11);
        send_byte(8'h22);
        in_data_i = 8'h33; abort_i = 1'b1;
        cycle();
        abort_i = 1'b0;
        send_frame(4, 70, 0, 0);
        send_byte(8'd5);
        send_byte(8'hA5);
        send_byte(8'hC3);
        in_valid_i = 1'b1; in_data_i = 8'h7E; abort_i = 1'b1;
        cycle();
        abort_i = 1'b0;
        send_frame(2, 71, 0, 0);
        in_valid_i = 1'b0; abort_i = 1'b1;
        cycle();
        abort_i = 1'b0;
        stall_mode = 1;
        send_frame(8, 72, 0, 1);
        stall_mode = 0;
        idle(4);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule